// File: doc/BRIEF.md
# Programmable Reference Divider and Phase-Frequency Detector

This block takes a reference clock, which is also the clock it runs on, and divides it down to a comparison clock. A 4-bit ratio code picks one of sixteen ratios. Eight are powers of two, from 2 to 256. The other eight are 3, 5, 10, 20, 40, 80, 160 and 320. A new code is taken up only at the end of the comparison period that is running, so no short period is ever produced. The comparison clock is compared with the feedback clock from the loop's programmable divider in a phase-frequency detector. The detector raises a pump-up request when the comparison edge arrives first and a pump-down request when the feedback edge arrives first. Once both requests are set, it clears them together.

A test-enable input and a 2-bit port-select field can override the pump. They can force it to sink continuously, force it to source continuously, or switch it off. The fourth override code leaves the detector running and routes the comparison clock and the feedback clock divided by two to two probe outputs. When the test enable is low, the port-select field has no effect. The feedback input is sampled on the reference clock, and only its rising edges count.

Top module: `refdiv_pfd`

## Requirements
- R1: With ratio_sel_i[3]=0, index ratio_sel_i[2:0] = k selects a comparison period of 2<<k reference cycles (2 to 256). The period is measured between consecutive rising edges of the comparison clock.
- R2: With ratio_sel_i[3]=1, index 0 selects a period of 3, index 1 selects 5, and index k>=1 selects 5<<(k-1) (10, 20, 40, 80, 160, 320).
- R3: For an even ratio N the comparison clock is high for N/2 reference cycles. For the odd ratios 3 and 5 it is high for exactly one cycle.
- R4: A ratio code applied during a period takes effect only at that period's terminal count. The running period completes with the old ratio, and the following period uses the new one.
- R5: While reset is asserted, and just after its release, up_o, dn_o, port1_o and port0_o are 0. With test_en_i=0, pump_en_o is 1.
- R6: If a comparison rising edge arrives while neither request is set, up_o rises one cycle after that edge appears on the comparison clock. It then stays high until a feedback rising edge arrives.
- R7: If a feedback rising edge (fb_clk_i going from 0 to 1 between two clock samples) arrives first, dn_o rises on that clock and stays high until the next comparison edge.
- R8: When both requests are high, they stay high together for exactly one cycle and are then both cleared. Coincident comparison and feedback edges give this one-cycle overlap on both outputs at once.
- R9: With test_en_i=1 and port_sel_i=00, the pump is forced to sink: dn_o=1, up_o=0, pump_en_o=1.
- R10: With test_en_i=1 and port_sel_i=01, the pump is forced to source: up_o=1, dn_o=0, pump_en_o=1.
- R11: With test_en_i=1 and port_sel_i=10, the pump is disabled: pump_en_o=0, up_o=0, dn_o=0.
- R12: With test_en_i=1 and port_sel_i=11, the detector drives up_o and dn_o as in normal operation. port1_o carries the comparison clock. port0_o toggles on each feedback rising edge and starts at 0 after reset.
- R13: With test_en_i=0, port_sel_i is ignored: port1_o=port0_o=0, pump_en_o=1, and up_o/dn_o come from the detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; every register of the block runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fb_clk_i | input | 1 | Feedback clock from the programmable divider, sampled on clk_i |
| ratio_sel_i | input | 4 | Bit 3 selects the ratio family, bits 2:0 select the index |
| test_en_i | input | 1 | Enables the test overrides selected by port_sel_i |
| port_sel_i | input | 2 | Override code: 00 sink, 01 source, 10 off, 11 probe |
| up_o | output | 1 | Pump-up (source) request |
| dn_o | output | 1 | Pump-down (sink) request |
| pump_en_o | output | 1 | Charge pump enable |
| port1_o | output | 1 | Probe output: comparison clock in probe mode, else 0 |
| port0_o | output | 1 | Probe output: feedback clock divided by two in probe mode, else 0 |

## Verification
The two detector events can fall in the same reference cycle: a comparison edge that sets the up request, and a feedback edge that sets the down request. The bench provokes this by watching the comparison clock on the probe port and raising the feedback input in the very cycle the comparison edge is seen. Both requests must then appear on the following cycle, together, for exactly one cycle, and be cleared on the cycle after that. A second case is also judged. In that case a clear of one overlap meets a pending edge, and the bench checks that neither request is lost or stuck when the next edges arrive.

// File: rtl/refdiv_pfd_pkg.sv
package refdiv_pfd_pkg;

    typedef enum logic [1:0] {
        OVR_SINK   = 2'b00,
        OVR_SOURCE = 2'b01,
        OVR_OFF    = 2'b10,
        OVR_PROBE  = 2'b11
    } ovr_mode_e;

    // Division ratio for a family bit and an index.
    function automatic int unsigned ratio_of(input logic fam, input int unsigned idx);
        if (!fam)
            return 32'd2 << idx;
        else if (idx == 0)
            return 32'd3;
        else
            return 32'd5 << (idx - 1);
    endfunction

    // Number of reference cycles the comparison clock stays high.
    function automatic int unsigned high_of(input logic fam, input int unsigned idx);
        if (!fam)
            return 32'd1 << idx;
        else if (idx < 2)
            return 32'd1;
        else
            return 32'd5 << (idx - 2);
    endfunction

endpackage

// File: rtl/refdiv_ratio_div.sv
module refdiv_ratio_div
    import refdiv_pfd_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W:0]   ratio_sel_i,
    output logic             cmp_o
);
    localparam int MAX_RATIO = 5 << ((1 << SEL_W) - 2);
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W:0]   code;
        logic             cmp;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] hi_next;
    logic             wrap;
    logic [SEL_W:0]   code_next;

    always_comb begin
        last_cnt  = CNT_W'(ratio_of(s_q.code[SEL_W], 32'(s_q.code[SEL_W-1:0])) - 1);
        wrap      = (s_q.cnt == last_cnt);
        code_next = wrap ? ratio_sel_i : s_q.code;
        hi_next   = CNT_W'(high_of(code_next[SEL_W], 32'(code_next[SEL_W-1:0])));
        s_d       = s_q;
        s_d.code  = code_next;
        if (wrap)
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + 1'b1;
        s_d.cmp = (s_d.cnt < hi_next);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cmp_o = s_q.cmp;

    // R4
    code_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.code) |-> (s_q.cnt == '0));

    // R3
    rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.cmp) |-> (s_q.cnt == '0));

    // R1
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(s_q.cnt) < MAX_RATIO);

endmodule

// File: rtl/refdiv_phase_det.sv
module refdiv_phase_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmp_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic fb_half_o
);
    typedef struct packed {
        logic cmp_prev;
        logic fb_prev;
        logic up;
        logic dn;
        logic fb_half;
    } pd_state_t;

    pd_state_t s_d, s_q;
    logic ref_edge;
    logic fb_edge;

    always_comb begin
        ref_edge     = cmp_i & ~s_q.cmp_prev;
        fb_edge      = fb_i & ~s_q.fb_prev;
        s_d          = s_q;
        s_d.cmp_prev = cmp_i;
        s_d.fb_prev  = fb_i;
        if (s_q.up && s_q.dn) begin
            s_d.up = ref_edge;
            s_d.dn = fb_edge;
        end else begin
            s_d.up = s_q.up | ref_edge;
            s_d.dn = s_q.dn | fb_edge;
        end
        if (fb_edge)
            s_d.fb_half = ~s_q.fb_half;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign up_o      = s_q.up;
    assign dn_o      = s_q.dn;
    assign fb_half_o = s_q.fb_half;

    // R8
    overlap_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.up && s_q.dn) |=> !(s_q.up && s_q.dn));

    // R6
    up_from_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.up) |-> $past(cmp_i && !s_q.cmp_prev));

    // R7
    dn_from_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.dn) |-> $past(fb_i && !s_q.fb_prev));

endmodule

// File: rtl/refdiv_pump_mode.sv
module refdiv_pump_mode
    import refdiv_pfd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       test_en_i,
    input  logic [1:0] port_sel_i,
    input  logic       up_i,
    input  logic       dn_i,
    input  logic       cmp_i,
    input  logic       fb_half_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       pump_en_o,
    output logic       port1_o,
    output logic       port0_o
);
    ovr_mode_e mode;

    always_comb begin
        mode      = ovr_mode_e'(port_sel_i);
        up_o      = up_i;
        dn_o      = dn_i;
        pump_en_o = 1'b1;
        port1_o   = 1'b0;
        port0_o   = 1'b0;
        if (test_en_i) begin
            unique case (mode)
                OVR_SINK: begin
                    up_o = 1'b0;
                    dn_o = 1'b1;
                end
                OVR_SOURCE: begin
                    up_o = 1'b1;
                    dn_o = 1'b0;
                end
                OVR_OFF: begin
                    up_o      = 1'b0;
                    dn_o      = 1'b0;
                    pump_en_o = 1'b0;
                end
                OVR_PROBE: begin
                    port1_o = cmp_i;
                    port0_o = fb_half_i;
                end
                default: ;
            endcase
        end
    end

    // R11
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pump_en_o |-> (!up_o && !dn_o));

    // R13
    normal_ports_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_en_i |-> (!port1_o && !port0_o && pump_en_o));

    // R9
    sink_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (test_en_i && port_sel_i == 2'b00) |-> (dn_o && !up_o));

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd #(
    parameter int SEL_W = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           fb_clk_i,
    input  logic [SEL_W:0] ratio_sel_i,
    input  logic           test_en_i,
    input  logic [1:0]     port_sel_i,
    output logic           up_o,
    output logic           dn_o,
    output logic           pump_en_o,
    output logic           port1_o,
    output logic           port0_o
);
    logic cmp_clk;
    logic pd_up;
    logic pd_dn;
    logic fb_half;

    refdiv_ratio_div #(.SEL_W(SEL_W)) u_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ratio_sel_i (ratio_sel_i),
        .cmp_o       (cmp_clk)
    );

    refdiv_phase_det u_pd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cmp_i     (cmp_clk),
        .fb_i      (fb_clk_i),
        .up_o      (pd_up),
        .dn_o      (pd_dn),
        .fb_half_o (fb_half)
    );

    refdiv_pump_mode u_mode (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .test_en_i  (test_en_i),
        .port_sel_i (port_sel_i),
        .up_i       (pd_up),
        .dn_i       (pd_dn),
        .cmp_i      (cmp_clk),
        .fb_half_i  (fb_half),
        .up_o       (up_o),
        .dn_o       (dn_o),
        .pump_en_o  (pump_en_o),
        .port1_o    (port1_o),
        .port0_o    (port0_o)
    );

endmodule

// File: tb/refdiv_pfd_tb_top.sv
`timescale 1ns/1ps
module refdiv_pfd_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fb = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       ten = 1'b0;
    logic [1:0] psel = 2'b00;
    logic       up, dn, pen, p1, p0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // code, period, high cycles
    localparam int TAB [16][3] = '{
        '{0, 2, 1},     '{1, 4, 2},     '{2, 8, 4},      '{3, 16, 8},
        '{4, 32, 16},   '{5, 64, 32},   '{6, 128, 64},   '{7, 256, 128},
        '{8, 3, 1},     '{9, 5, 1},     '{10, 10, 5},    '{11, 20, 10},
        '{12, 40, 20},  '{13, 80, 40},  '{14, 160, 80},  '{15, 320, 160}
    };

    refdiv_pfd dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fb_clk_i(fb), .ratio_sel_i(sel),
        .test_en_i(ten), .port_sel_i(psel), .up_o(up), .dn_o(dn),
        .pump_en_o(pen), .port1_o(p1), .port0_o(p0)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = p1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (p1 && !prev) return;
            prev = p1;
        end
        chk("wait_rise timeout", 0, 1);
    endtask

    // Called at the negedge where a rising edge was just seen.
    task automatic measure(output int per, output int hi);
        logic prev;
        prev = 1'b1;
        per = 1;
        hi = 1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (p1 && !prev) return;
            per++;
            if (p1) hi++;
            prev = p1;
        end
        chk("measure timeout", 0, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int per, hi;
        // R5 reset state
        repeat (2) @(negedge clk);
        chk("R5 up in reset", up, 0);
        chk("R5 dn in reset", dn, 0);
        chk("R5 pump_en in reset", pen, 1);
        chk("R5 port1 in reset", p1, 0);
        rst_n = 1'b1;
        #1;
        chk("R5 port0 after release", p0, 0);
        chk("R5 dn after release", dn, 0);

        // R1 R2 R3 ratio table sweep in probe mode
        ten = 1'b1;
        psel = 2'b11;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sel = 4'(TAB[i][0]);
            wait_rise();
            measure(per, hi);
            chk(TAB[i][0] < 8 ? "R1 period" : "R2 period", per, TAB[i][1]);
            chk("R3 high time", hi, TAB[i][2]);
        end

        // R4 ratio change mid-period: old period completes, then new one
        sel = 4'd3;
        do_reset();
        wait_rise();
        wait_rise();
        sel = 4'd8;
        measure(per, hi);
        chk("R4 old period", per, 16);
        chk("R4 old high", hi, 8);
        measure(per, hi);
        chk("R4 new period", per, 3);
        chk("R4 new high", hi, 1);

        // Detector scenarios, ratio 8, probe mode
        sel = 4'd2;
        do_reset();
        wait_rise();                // rise k
        fb = 1'b1;                  // coincident feedback edge
        @(negedge clk);             // k+1
        chk("R8 coincident up", up, 1);
        chk("R8 coincident dn", dn, 1);
        fb = 1'b0;
        @(negedge clk);             // k+2
        chk("R8 cleared up", up, 0);
        chk("R8 cleared dn", dn, 0);
        @(negedge clk);             // k+3
        fb = 1'b1;                  // feedback leads
        @(negedge clk);             // k+4
        chk("R7 dn on fb lead", dn, 1);
        chk("R7 up idle", up, 0);
        fb = 1'b0;
        wait_rise();                // k+8
        chk("R7 dn held", dn, 1);
        @(negedge clk);             // k+9
        chk("R8 overlap up", up, 1);
        chk("R8 overlap dn", dn, 1);
        @(negedge clk);             // k+10
        chk("R8 clear up", up, 0);
        chk("R8 clear dn", dn, 0);
        wait_rise();                // k+16, reference leads
        chk("R6 up not yet", up, 0);
        @(negedge clk);
        chk("R6 up set", up, 1);
        chk("R6 dn idle", dn, 0);
        @(negedge clk);
        chk("R6 up held", up, 1);
        fb = 1'b1;
        @(negedge clk);
        chk("R8 late overlap dn", dn, 1);
        fb = 1'b0;
        @(negedge clk);
        chk("R8 late clear up", up, 0);

        // Overrides
        psel = 2'b00;
        #1;
        chk("R9 sink dn", dn, 1);
        chk("R9 sink up", up, 0);
        chk("R9 sink pump_en", pen, 1);
        psel = 2'b01;
        #1;
        chk("R10 source up", up, 1);
        chk("R10 source dn", dn, 0);
        psel = 2'b10;
        #1;
        chk("R11 off pump_en", pen, 0);
        chk("R11 off up", up, 0);
        chk("R11 off dn", dn, 0);
        ten = 1'b0;
        psel = 2'b00;
        #1;
        chk("R13 ignored sink dn", dn, 0);
        chk("R13 pump_en", pen, 1);
        psel = 2'b11;
        repeat (12) @(negedge clk);
        chk("R13 port1 quiet", p1, 0);
        chk("R13 port0 quiet", p0, 0);
        psel = 2'b10;
        #1;
        chk("R13 ignored off", pen, 1);

        // R12 feedback divided by two on port0
        ten = 1'b1;
        psel = 2'b11;
        do_reset();
        #1;
        chk("R12 port0 start", p0, 0);
        fb = 1'b1;
        @(negedge clk);
        chk("R12 port0 toggle1", p0, 1);
        fb = 1'b0;
        @(negedge clk);
        chk("R12 port0 hold", p0, 1);
        fb = 1'b1;
        @(negedge clk);
        chk("R12 port0 toggle2", p0, 0);
        fb = 1'b0;
        wait_rise();
        chk("R12 port1 carries cmp", p1, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule